// File: doc/BRIEF.md
# Burst Column Address Counter

This block produces the column address for every word of a page-mode DRAM burst. A load captures the burst start address. After that, each advance moves the column by one 32-bit word, which is 4 bytes. The direction of travel depends on where the start address falls inside a 16-byte line. A start offset of 0xC walks downward. Every other offset walks upward. The direction is captured at load time and does not change for the rest of the burst.

The block counts how many words the current page run has issued. It compares that count with a programmed words-per-page limit. An advance that would go past the limit raises a one-cycle page-miss pulse. An advance that would carry the 12-bit column past either end of its range also raises the pulse. On a miss, the counter reloads from the current bus address, takes its direction again from that address, and restarts its word count. The memory controller uses the pulse to close the row and open a new one. The counter has no software-visible state.

Top module: `burst_col_counter`

## Requirements
- R1: While reset is applied, and on the first cycle after it, `col_o` is 0 and `miss_o` is 0. Reset leaves the direction set to ascending and the word count at zero.
- R2: When `load_i` is high, `col_o` equals `bus_addr_i` on the next cycle and `miss_o` is 0 on that cycle. A load takes priority over an advance presented in the same cycle.
- R3: In an ascending burst, an advance with no miss raises `col_o` by 4 on the next cycle. A burst ascends when bits [3:0] of the load address are anything other than 4'hC.
- R4: In a descending burst, an advance with no miss lowers `col_o` by 4 on the next cycle. A burst descends when bits [3:0] of the load address are 4'hC. Changes on `bus_addr_i` during the burst do not alter the direction.
- R5: Let N be `page_words_i`. After a load, the load word counts as word 1. The advance that would issue word N+1 causes a miss, so with N ≤ 1 every advance causes a miss.
- R6: An advance that would carry the column above 12'hFFC when ascending, or below 0 when descending, causes a miss instead of wrapping.
- R7: On a miss, `miss_o` is 1 for one cycle and `col_o` equals the `bus_addr_i` of the miss cycle. The direction is taken again from bits [3:0] of that address, and the word count restarts as if a load had occurred.
- R8: In a cycle with neither load nor advance, `col_o` holds its value and `miss_o` is 0 on the next cycle.
- R9: `miss_o` is only ever 1 on the cycle after an advance that was not accompanied by a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; it is released synchronously inside the block |
| load_i | input | 1 | Start a burst at `bus_addr_i` |
| advance_i | input | 1 | Step to the next word of the burst |
| bus_addr_i | input | 12 | Current bus column address, used on a load or a miss |
| page_words_i | input | 12 | Number of column words allowed per page run |
| col_o | output | 12 | Current column address |
| miss_o | output | 1 | One-cycle page-miss pulse |

## Verification
Every result is registered and is due exactly one clock edge after the inputs that cause it. This holds for the new column value after a load, a step or a reload, and for the miss pulse. The one exception is the asynchronous clear of reset, which takes effect at once. The bench drives its inputs on the falling edge and checks outputs on the next falling edge, so each check falls half a cycle after the rising edge that registered the result. After reset is released, the bench waits out the two-stage synchronizer before it presents any stimulus.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } col_dir_e;

endpackage

// File: rtl/bcc_rst_sync.sv
module bcc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bcc_dir_pick.sv
module bcc_dir_pick
  import burst_col_pkg::*;
#(
  parameter int              LINE_W   = 4,
  parameter logic [LINE_W-1:0] DOWN_OFS = 4'hC
) (
  input  logic [LINE_W-1:0] line_ofs,
  output col_dir_e          dir
);

  always_comb begin
    if (line_ofs == DOWN_OFS) begin
      dir = DIR_DOWN;
    end else begin
      dir = DIR_UP;
    end
  end

endmodule

// File: rtl/bcc_col_step.sv
module bcc_col_step
  import burst_col_pkg::*;
#(
  parameter int COL_W = 12,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             step_en,
  input  logic [COL_W-1:0] load_val,
  input  col_dir_e         load_dir,
  output logic [COL_W-1:0] col_q,
  output col_dir_e         dir_q,
  output logic             wrap_o
);

  localparam logic [COL_W-1:0] STEP_V = COL_W'(STEP);
  localparam logic [COL_W-1:0] MAX_V  = {COL_W{1'b1}};
  localparam logic [COL_W-1:0] UP_LIM = MAX_V - STEP_V;

  logic [COL_W-1:0] col_d;
  col_dir_e         dir_d;
  logic             col_en;

  always_comb begin
    if (dir_q == DIR_UP) begin
      wrap_o = (col_q > UP_LIM);
    end else begin
      wrap_o = (col_q < STEP_V);
    end
  end

  always_comb begin
    col_en = load_en | step_en;
    col_d  = col_q;
    dir_d  = dir_q;
    if (load_en) begin
      col_d = load_val;
      dir_d = load_dir;
    end else if (step_en) begin
      if (dir_q == DIR_UP) begin
        col_d = col_q + STEP_V;
      end else begin
        col_d = col_q - STEP_V;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      dir_q <= DIR_UP;
    end else if (col_en) begin
      col_q <= col_d;
      dir_q <= dir_d;
    end
  end

endmodule

// File: rtl/bcc_word_meter.sv
module bcc_word_meter #(
  parameter int PW_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            incr,
  input  logic [PW_W-1:0] limit,
  output logic            at_limit
);

  logic [PW_W-1:0] cnt_q;
  logic [PW_W-1:0] cnt_d;
  logic            cnt_en;
  logic [PW_W:0]   issued;

  always_comb begin
    issued   = {1'b0, cnt_q} + {{PW_W{1'b0}}, 1'b1};
    at_limit = (issued >= {1'b0, limit});
  end

  always_comb begin
    cnt_en = clear | incr;
    if (clear) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + {{(PW_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/burst_col_counter.sv
module burst_col_counter
  import burst_col_pkg::*;
#(
  parameter int COL_W    = 12,
  parameter int PW_W     = 12,
  parameter int STEP     = 4,
  parameter int LINE_W   = 4,
  parameter int SYNC_STG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             advance_i,
  input  logic [COL_W-1:0] bus_addr_i,
  input  logic [PW_W-1:0]  page_words_i,
  output logic [COL_W-1:0] col_o,
  output logic             miss_o
);

  localparam logic [LINE_W-1:0] DOWN_OFS = LINE_W'(16 - STEP);

  logic     rst_sync_n;
  col_dir_e pick_dir;
  col_dir_e dir_q;
  logic     wrap;
  logic     at_limit;
  logic     miss_now;
  logic     reload;
  logic     step;
  logic     miss_d;
  logic     miss_q;

  bcc_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bcc_dir_pick #(.LINE_W(LINE_W), .DOWN_OFS(DOWN_OFS)) u_dir (
    .line_ofs (bus_addr_i[LINE_W-1:0]),
    .dir      (pick_dir)
  );

  always_comb begin
    miss_now = advance_i & ~load_i & (wrap | at_limit);
    reload   = load_i | miss_now;
    step     = advance_i & ~load_i & ~miss_now;
    miss_d   = miss_now;
  end

  bcc_col_step #(.COL_W(COL_W), .STEP(STEP)) u_col (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_en  (reload),
    .step_en  (step),
    .load_val (bus_addr_i),
    .load_dir (pick_dir),
    .col_q    (col_o),
    .dir_q    (dir_q),
    .wrap_o   (wrap)
  );

  bcc_word_meter #(.PW_W(PW_W)) u_meter (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clear    (reload),
    .incr     (step),
    .limit    (page_words_i),
    .at_limit (at_limit)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      miss_q <= 1'b0;
    end else begin
      miss_q <= miss_d;
    end
  end

  assign miss_o = miss_q;

endmodule

// File: rtl/burst_col_counter_chk.sv
module burst_col_counter_chk #(
  parameter int COL_W = 12,
  parameter int STEP  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_i,
  input logic             advance_i,
  input logic [COL_W-1:0] bus_addr_i,
  input logic [COL_W-1:0] col_o,
  input logic             miss_o,
  input logic             dir_dn
);

  localparam logic [COL_W-1:0] STEP_V = COL_W'(STEP);
  localparam logic [COL_W-1:0] UP_LIM = {COL_W{1'b1}} - STEP_V;

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (col_o == '0) && !miss_o);

  a_r2_load_takes_addr: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (col_o == $past(bus_addr_i)) && !miss_o);

  a_r3_ascend_step: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !miss_o && $past(advance_i) && !$past(load_i) && !$past(dir_dn))
      |-> (col_o == $past(col_o) + STEP_V));

  a_r4_descend_step: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !miss_o && $past(advance_i) && !$past(load_i) && $past(dir_dn))
      |-> (col_o == $past(col_o) - STEP_V));

  a_r6_wrap_misses: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !load_i &&
     ((!dir_dn && (col_o > UP_LIM)) || (dir_dn && (col_o < STEP_V))))
      |=> miss_o);

  a_r7_reload_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && miss_o) |-> (col_o == $past(bus_addr_i)));

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !advance_i) |=> $stable(col_o) && !miss_o);

  a_r9_miss_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && miss_o) |-> ($past(advance_i) && !$past(load_i)));

endmodule

bind burst_col_counter burst_col_counter_chk #(.COL_W(COL_W), .STEP(STEP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .load_i     (load_i),
  .advance_i  (advance_i),
  .bus_addr_i (bus_addr_i),
  .col_o      (col_o),
  .miss_o     (miss_o),
  .dir_dn     (dir_q == burst_col_pkg::DIR_DOWN)
);

// File: tb/burst_col_counter_test.sv
module burst_col_counter_test;

  localparam int NV = 32;
  localparam int VW = 43;

  // {req[3:0], load, advance, bus_addr[11:0], page_words[11:0], exp_col[11:0], exp_miss}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd2, 1'b1, 1'b0, 12'h100, 12'd8,     12'h100, 1'b0},  // R2 load
    {4'd3, 1'b0, 1'b1, 12'h200, 12'd8,     12'h104, 1'b0},  // R3
    {4'd3, 1'b0, 1'b1, 12'h200, 12'd8,     12'h108, 1'b0},  // R3
    {4'd3, 1'b0, 1'b1, 12'h200, 12'd8,     12'h10C, 1'b0},  // R3
    {4'd2, 1'b1, 1'b0, 12'h04C, 12'd8,     12'h04C, 1'b0},  // R2 load, offset C
    {4'd4, 1'b0, 1'b1, 12'h200, 12'd8,     12'h048, 1'b0},  // R4
    {4'd4, 1'b0, 1'b1, 12'h200, 12'd8,     12'h044, 1'b0},  // R4
    {4'd8, 1'b0, 1'b0, 12'h7FF, 12'd8,     12'h044, 1'b0},  // R8 idle
    {4'd2, 1'b1, 1'b0, 12'h300, 12'd3,     12'h300, 1'b0},  // R2
    {4'd5, 1'b0, 1'b1, 12'h500, 12'd3,     12'h304, 1'b0},  // R5 word 2
    {4'd5, 1'b0, 1'b1, 12'h500, 12'd3,     12'h308, 1'b0},  // R5 word 3
    {4'd5, 1'b0, 1'b1, 12'h500, 12'd3,     12'h500, 1'b1},  // R5 overrun
    {4'd7, 1'b0, 1'b1, 12'h600, 12'd3,     12'h504, 1'b0},  // R7 count restarted
    {4'd7, 1'b0, 1'b1, 12'h600, 12'd3,     12'h508, 1'b0},  // R7
    {4'd7, 1'b0, 1'b1, 12'h600, 12'd3,     12'h600, 1'b1},  // R7 next overrun
    {4'd2, 1'b1, 1'b0, 12'hFF0, 12'hFFF,   12'hFF0, 1'b0},  // R2
    {4'd3, 1'b0, 1'b1, 12'h010, 12'hFFF,   12'hFF4, 1'b0},  // R3
    {4'd3, 1'b0, 1'b1, 12'h010, 12'hFFF,   12'hFF8, 1'b0},  // R3
    {4'd3, 1'b0, 1'b1, 12'h010, 12'hFFF,   12'hFFC, 1'b0},  // R3
    {4'd6, 1'b0, 1'b1, 12'h010, 12'hFFF,   12'h010, 1'b1},  // R6 top wrap
    {4'd2, 1'b1, 1'b0, 12'h00C, 12'hFFF,   12'h00C, 1'b0},  // R2
    {4'd4, 1'b0, 1'b1, 12'h0A0, 12'hFFF,   12'h008, 1'b0},  // R4
    {4'd4, 1'b0, 1'b1, 12'h0A0, 12'hFFF,   12'h004, 1'b0},  // R4
    {4'd4, 1'b0, 1'b1, 12'h0A0, 12'hFFF,   12'h000, 1'b0},  // R4
    {4'd6, 1'b0, 1'b1, 12'h0A0, 12'hFFF,   12'h0A0, 1'b1},  // R6 bottom wrap
    {4'd2, 1'b1, 1'b1, 12'h080, 12'hFFF,   12'h080, 1'b0},  // R2 load beats advance
    {4'd8, 1'b0, 1'b0, 12'h000, 12'hFFF,   12'h080, 1'b0},  // R8
    {4'd2, 1'b1, 1'b0, 12'h1E0, 12'd1,     12'h1E0, 1'b0},  // R2
    {4'd5, 1'b0, 1'b1, 12'h7C0, 12'd1,     12'h7C0, 1'b1},  // R5 limit one
    {4'd7, 1'b0, 1'b1, 12'h2AC, 12'd1,     12'h2AC, 1'b1},  // R7 reload picks down
    {4'd4, 1'b0, 1'b1, 12'h111, 12'd8,     12'h2A8, 1'b0},  // R4 dir held
    {4'd4, 1'b0, 1'b1, 12'h111, 12'd8,     12'h2A4, 1'b0}   // R4
  };

  logic        clk;
  logic        rst_n;
  logic        load_i;
  logic        advance_i;
  logic [11:0] bus_addr_i;
  logic [11:0] page_words_i;
  logic [11:0] col_o;
  logic        miss_o;

  int checks;
  int errors;
  bit done;

  burst_col_counter uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_i),
    .advance_i    (advance_i),
    .bus_addr_i   (bus_addr_i),
    .page_words_i (page_words_i),
    .col_o        (col_o),
    .miss_o       (miss_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [11:0] exp_col, input logic exp_miss);
    checks++;
    if (col_o !== exp_col || miss_o !== exp_miss) begin
      errors++;
      $display("FAIL %s col=%h miss=%b expected col=%h miss=%b", req, col_o, miss_o, exp_col, exp_miss);
    end
  endtask

  task automatic drive(input logic ld, input logic adv, input logic [11:0] a, input logic [11:0] pw);
    load_i       = ld;
    advance_i    = adv;
    bus_addr_i   = a;
    page_words_i = pw;
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    drive(1'b0, 1'b0, 12'h000, 12'd8);
    repeat (3) @(negedge clk);
    check("R1", 12'h000, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", 12'h000, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][38], VEC[i][37], VEC[i][36:25], VEC[i][24:13]);
      @(negedge clk);
      check($sformatf("R%0d row %0d", VEC[i][42:39], i), VEC[i][12:1], VEC[i][0]);
    end

    // R1: asynchronous clear while a burst is in progress
    drive(1'b0, 1'b0, 12'h000, 12'd8);
    rst_n = 1'b0;
    #1;
    check("R1 async", 12'h000, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", 12'h000, 1'b0);

    // R3: reset direction ascends, count starts at zero
    drive(1'b0, 1'b1, 12'h3CC, 12'd8);
    @(negedge clk);
    check("R3 from reset", 12'h004, 1'b0);

    // R9: a load never yields a miss even with limit zero
    drive(1'b1, 1'b1, 12'h0F0, 12'd0);
    @(negedge clk);
    check("R9 load", 12'h0F0, 1'b0);
    drive(1'b0, 1'b1, 12'h220, 12'd0);
    @(negedge clk);
    check("R5 limit zero", 12'h220, 1'b1);
    drive(1'b0, 1'b0, 12'h220, 12'd0);
    @(negedge clk);
    check("R9 pulse ends", 12'h220, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule